// File: doc/BRIEF.md
# Time-Shared Half-Rate FIR Decimator

This block is a 65-tap low-pass FIR filter that halves the sample rate. It uses one multiply-accumulate datapath and reuses it for every tap of an output. Incoming 16-bit signed samples are offered with a load strobe. The block takes a sample only while its ready flag is high and writes it into a 65-entry circular sample memory.

Every second accepted sample starts an integration period. During that period a small sequencer walks two read pointers through the memory, one running back from the newest sample and one running forward from the oldest. It reads the matching entry of an internal coefficient set. The coefficients are linear-phase symmetric, so the two samples that share a coefficient are summed in a pre-adder before the multiply. Because of that, 33 products make up each output. The result is kept at full precision, registered, and marked by a one-cycle valid pulse.

The block sits in a receive chain in front of a slower processing stage. The input ready flag paces the upstream source, and no output is ever computed only to be thrown away.

Top module: `mac_decim_fir`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `out_data` is 0. Every sample-memory entry reads as zero, so the samples before the first accepted one count as 0.
- R2: A sample is accepted at a rising clock edge when `in_load` and `in_ready` are both 1. The value on `in_data` becomes the newest sample x[n].
- R3: Counting accepted samples from reset, exactly the 2nd, 4th, 6th, … accepted sample each produce one output. After an odd-numbered accepted sample, `in_ready` stays 1.
- R4: The output for newest sample x[n] equals sum over k = 0..64 of h[k]·x[n−k]. The coefficients are h[k] = 29·(k+1)² − 6000 for k = 0..32 and h[k] = h[64−k] for k = 33..64. All values are signed integers.
- R5: `out_data` is the exact 40-bit two's-complement sum with no rounding, truncation or saturation, including runs of full-scale positive (32767) and full-scale negative (−32768) inputs.
- R6: After the rising edge that accepts an even-numbered sample, `in_ready` is 0. `out_valid` and the new `out_data` appear after the 33rd rising edge that follows the accepting edge.
- R7: While `in_ready` is 0, `in_load` and `in_data` have no effect. A sample offered then never enters the computation.
- R8: `out_valid` is high for exactly one clock cycle per output.
- R9: `out_data` holds its value in every cycle in which `out_valid` is 0.
- R10: `in_ready` returns to 1 in the same cycle in which `out_valid` is 1. A sample offered in that cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 16 | Signed input sample |
| in_load | input | 1 | Offers `in_data` for acceptance |
| in_ready | output | 1 | High when a sample can be accepted |
| out_data | output | 40 | Signed full-precision filter output, registered |
| out_valid | output | 1 | One-cycle pulse when `out_data` carries a new result |

## Verification
Two functions can land in the same cycle: the output pulse that ends an integration period, and the acceptance of the next sample, because the ready flag comes back in that very cycle. The bench provokes this by offering each new sample in the cycle where it sees the valid pulse. It then checks that the sample was taken and that the output after it still matches the direct-form reference. The bench also holds the load strobe high with junk data through the final busy cycle just before ready returns. The reference excludes that junk, so any leak into the sample memory shows up as a wrong later output.

// File: rtl/mac_decim_fir.sv
module mac_decim_fir #(
  parameter int NTAPS = 65,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int OW    = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] in_data,
  input  logic                 in_load,
  output logic                 in_ready,
  output logic signed [OW-1:0] out_data,
  output logic                 out_valid
);
  localparam int HALF = (NTAPS - 1) / 2;
  localparam int AWID = $clog2(NTAPS);
  localparam int KW   = $clog2(HALF + 1);
  localparam int PW   = DW + 1 + CW;
  localparam logic [AWID-1:0] PLAST = AWID'(NTAPS - 1);
  localparam logic [KW-1:0]   KLAST = KW'(HALF);

  logic signed [DW-1:0] mem [NTAPS];
  logic [AWID-1:0] wptr, pa, pb;
  logic [KW-1:0]   k;
  logic            busy, phase;
  logic signed [OW-1:0] acc, acc_nx;
  logic signed [DW:0]   pre;
  logic signed [CW-1:0] cf;
  logic signed [PW-1:0] prod;
  logic accept;

  function automatic logic signed [CW-1:0] coef_at(input logic [KW-1:0] idx);
    int v;
    v = 29 * (int'(idx) + 1) * (int'(idx) + 1) - 6000;
    return v[CW-1:0];
  endfunction

  function automatic logic [AWID-1:0] inc(input logic [AWID-1:0] p);
    return (p == PLAST) ? '0 : p + AWID'(1);
  endfunction

  function automatic logic [AWID-1:0] dec(input logic [AWID-1:0] p);
    return (p == '0) ? PLAST : p - AWID'(1);
  endfunction

  assign in_ready = ~busy;
  assign accept   = in_load & ~busy;

  assign pre    = (k == KLAST) ? {mem[pa][DW-1], mem[pa]}
                               : {mem[pa][DW-1], mem[pa]} + {mem[pb][DW-1], mem[pb]};
  assign cf     = coef_at(k);
  assign prod   = pre * cf;
  assign acc_nx = acc + {{(OW-PW){prod[PW-1]}}, prod};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTAPS; i++) mem[i] <= '0;
      wptr      <= '0;
      pa        <= '0;
      pb        <= '0;
      k         <= '0;
      busy      <= 1'b0;
      phase     <= 1'b0;
      acc       <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (accept) begin
        mem[wptr] <= in_data;
        wptr      <= inc(wptr);
        phase     <= ~phase;
        if (phase) begin
          busy <= 1'b1;
          pa   <= wptr;
          pb   <= inc(wptr);
          k    <= '0;
          acc  <= '0;
        end
      end else if (busy) begin
        acc <= acc_nx;
        pa  <= dec(pa);
        pb  <= inc(pb);
        k   <= k + KW'(1);
        if (k == KLAST) begin
          out_data  <= acc_nx;
          out_valid <= 1'b1;
          busy      <= 1'b0;
        end
      end
    end
  end

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

  // R10
  ready_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);

  // R6
  busy_after_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_load && in_ready && phase) |=> !in_ready);

  // R7
  ignore_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready) |=> $stable(wptr));

  // R3
  odd_stays_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_load && in_ready && !phase) |=> in_ready);

  // R6
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (k <= KLAST));
endmodule

// File: tb/mac_decim_fir_tb.sv
module mac_decim_fir_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [15:0] in_data = '0;
  logic in_load = 1'b0;
  logic in_ready, out_valid;
  logic signed [39:0] out_data;

  int errors = 0;
  int checks = 0;
  int hist [65];
  int naccept = 0;
  longint last_out = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  mac_decim_fir u_dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_load(in_load),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid)
  );

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      finish_run();
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint hcoef(input int k);
    int j;
    j = (k <= 32) ? k : 64 - k;
    return longint'(29 * (j + 1) * (j + 1) - 6000);
  endfunction

  function automatic longint ref_out();
    longint s = 0;
    for (int k = 0; k < 65; k++) s += hcoef(k) * longint'(hist[k]);
    return s;
  endfunction

  // Called just after a negedge; returns just after a negedge.
  task automatic push(input int v, input bit noise);
    bit busy_ok;
    longint exp;
    check("R2 in_ready before offer", in_ready, 1);
    in_load = 1'b1;
    in_data = 16'(v);
    @(negedge clk);
    in_load = 1'b0;
    for (int i = 64; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = v;
    naccept++;
    check("R8 valid is a single pulse", out_valid, 0);
    if (naccept % 2 == 1) begin
      check("R3 ready stays high after odd sample", in_ready, 1);
      return;
    end
    exp = ref_out();
    busy_ok = 1'b1;
    for (int i = 0; i <= 32; i++) begin
      if (in_ready !== 1'b0 || out_valid !== 1'b0 || longint'(out_data) != last_out)
        busy_ok = 1'b0;
      if (noise) begin
        in_load = 1'b1;
        in_data = 16'(12345 + i * 777);
      end
      @(negedge clk);
    end
    in_load = 1'b0;
    check("R6/R9 busy window ready low, output held", busy_ok, 1);
    check("R6 valid after 33 edges", out_valid, 1);
    check("R10 ready back with valid", in_ready, 1);
    check("R4/R5 output value", longint'(out_data), exp);
    last_out = exp;
  endtask

  task automatic idle(input int n);
    bit ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (out_valid !== 1'b0 || longint'(out_data) != last_out || in_ready !== 1'b1) ok = 1'b0;
    end
    check("R9 idle gap output held", ok, 1);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 65; i++) hist[i] = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset in_ready", in_ready, 1);
    check("R1 reset out_valid", out_valid, 0);
    check("R1 reset out_data", longint'(out_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_impulse();
    push(1000, 0);
    for (int i = 0; i < 69; i++) push(0, 0);
  endtask

  task automatic t_extremes();
    for (int i = 0; i < 66; i++) push(32767, 0);
    for (int i = 0; i < 66; i++) push(-32768, 0);
    for (int i = 0; i < 40; i++) push((i % 2) ? 32767 : -32768, 0);
  endtask

  task automatic t_noise();
    for (int i = 0; i < 30; i++) push(i * 311 - 4000, 1);
  endtask

  task automatic t_gaps();
    int s = 7;
    for (int i = 0; i < 40; i++) begin
      s = (s * 1103 + 12345) % 65536;
      push(s - 32768, 0);
      if (i % 3 == 0) idle(1 + i % 4);
    end
  endtask

  initial begin
    t_reset();
    t_impulse();
    t_extremes();
    t_noise();
    t_gaps();
    finish_run();
  end
endmodule